// File: doc/BRIEF.md
# Raster Line Video FIFO

This block buffers one printed raster line between system memory and a laser print engine. A DMA controller fills it one byte at a time: the block raises a request while it has room for at least one more word, and it stores a word on every acknowledge. When the engine reaches the start of a line, a pulse on `line_start` begins the drain. The stored bytes then leave as a single serial video bit stream, most significant bit first, at a fixed pixel rate. That rate comes from a fractional clock enable derived from the system clock.

The programmed line length is counted in bits, so it does not have to be a whole number of bytes. Each line starts on a fresh byte, and any unsent bits of the last byte taken are discarded. If the store runs dry while bits are still owed, the video output sends zeros and a sticky underrun flag is raised. A write acknowledged while the store is full is dropped and raises a sticky overflow flag. With the default parameters the store holds 1280 bytes, which is 10 Kbit. The default enable ratio of 613/25000 gives 6.13 MHz from a 250 MHz system clock.

Top module: `rline_vfifo`

## Requirements
- R1: `dma_req` is high exactly when fewer than `DEPTH` words are stored, and it is high after reset.
- R2: A write acknowledged while the store is not full keeps the byte. Bytes are serialised in the order they were written, including writes made while a line is running.
- R3: A write acknowledged while the store is full leaves the stored data unchanged and sets the sticky `overflow` flag.
- R4: The internal bit enable is high after system clock edge k (counted from reset release) exactly when floor(k·RATE_NUM/RATE_DEN) > floor((k−1)·RATE_NUM/RATE_DEN). While a line runs, each enable emits one bit on the next edge, and `video_vld` is high for that one cycle.
- R5: Each byte is sent most significant bit first. `video_out` holds its value between bits.
- R6: `line_start` while idle with a non-zero `line_len` raises `line_active` and sends exactly `line_len` bits. The first bit of a line always comes from a newly fetched byte, and leftover bits of a byte from the previous line are dropped.
- R7: `line_done` pulses for one cycle together with the last bit of a line, and `line_active` falls in the same cycle.
- R8: `line_start` while a line is active has no effect.
- R9: When a new byte is needed and the store is empty, that bit slot sends 0, still counts toward the line length, and sets the sticky `underrun` flag.
- R10: An accepted `line_start` clears `underrun` and `overflow`. If a full-store write happens in the same cycle, `overflow` ends up set.
- R11: An accepted `line_start` with `line_len` of 0 pulses `line_done` on the next edge, sends no bits, and leaves `line_active` low.
- R12: After reset, `video_out`, `video_vld`, `line_active`, `line_done`, `underrun` and `overflow` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dma_req | output | 1 | Room for at least one more word |
| dma_ack | input | 1 | Write strobe from the DMA controller |
| dma_data | input | DATA_W | Word to store |
| line_start | input | 1 | Begin shifting a line |
| line_len | input | LEN_W | Line length in bits, sampled at an accepted start |
| video_out | output | 1 | Serial video bit |
| video_vld | output | 1 | New bit on `video_out` this cycle |
| line_active | output | 1 | A line is being shifted |
| line_done | output | 1 | One-cycle pulse with the last bit of a line |
| underrun | output | 1 | Sticky: a bit slot found the store empty |
| overflow | output | 1 | Sticky: a write arrived while the store was full |

## Verification
The drain is tried with several patterns. A whole number of bytes with mixed bit patterns shows the bit order and the byte order. A 12-bit line shows that leftover bits are dropped at the line boundary and that the next line starts on a fresh byte. A line longer than the stored data shows the switch from real bits to zero fill and when the underrun flag rises. A full store that is drained while new writes arrive separates correct wrap-around and simultaneous push/pop handling from pointer or count errors. A behavioural queue model predicts every output on every clock, so a bit enable arriving early or late shows up as a `video_vld` mismatch, not only as wrong data.

// File: rtl/vf_pkg.sv
package vf_pkg;
   typedef enum logic {
      SER_IDLE = 1'b0,
      SER_RUN  = 1'b1
   } ser_state_t;
endpackage

// File: rtl/vf_rate_gen.sv
module vf_rate_gen #(
   parameter int RATE_NUM = 613,
   parameter int RATE_DEN = 25000
) (
   input  logic clk,
   input  logic rst_n,
   output logic bit_en
);
   generate
      if (RATE_NUM < 1 || RATE_NUM > RATE_DEN) begin : g_bad_ratio
         $error("vf_rate_gen: RATE_NUM must lie in 1..RATE_DEN");
      end

      if (RATE_NUM == RATE_DEN) begin : g_every
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) bit_en <= 1'b0;
            else        bit_en <= 1'b1;
         end
      end else begin : g_frac
         localparam int ACC_W = $clog2(RATE_DEN + RATE_NUM) + 1;
         logic [ACC_W-1:0] acc_q;
         logic [ACC_W-1:0] acc_sum;

         assign acc_sum = acc_q + ACC_W'(RATE_NUM);

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               acc_q  <= '0;
               bit_en <= 1'b0;
            end else if (acc_sum >= ACC_W'(RATE_DEN)) begin
               acc_q  <= acc_sum - ACC_W'(RATE_DEN);
               bit_en <= 1'b1;
            end else begin
               acc_q  <= acc_sum;
               bit_en <= 1'b0;
            end
         end

         // R4
         acc_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
            acc_q < ACC_W'(RATE_DEN));

         if (2 * RATE_NUM <= RATE_DEN) begin : g_gap
            // R4
            en_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
               bit_en |=> !bit_en);
         end
      end
   endgenerate
endmodule

// File: rtl/vf_store.sv
module vf_store #(
   parameter int DATA_W = 8,
   parameter int DEPTH  = 1280
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_ack,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              rd_pop,
   output logic [DATA_W-1:0] rd_data,
   output logic              empty,
   output logic              dma_req,
   input  logic              ovf_clr,
   output logic              overflow
);
   localparam int  AW   = $clog2(DEPTH);
   localparam int  CW   = $clog2(DEPTH + 1);
   localparam bit  POW2 = (DEPTH == (1 << AW));

   generate
      if (DEPTH < 2) begin : g_bad_depth
         $error("vf_store: DEPTH must be at least 2");
      end
      if (DATA_W < 1) begin : g_bad_width
         $error("vf_store: DATA_W must be at least 1");
      end
   endgenerate

   logic [DATA_W-1:0] mem_q [DEPTH];
   logic [AW-1:0]     wp_q, rp_q, wp_nx, rp_nx;
   logic [CW-1:0]     cnt_q;
   logic              full, do_wr, do_rd;

   assign full    = (cnt_q == CW'(DEPTH));
   assign empty   = (cnt_q == '0);
   assign dma_req = !full;
   assign do_wr   = wr_ack && !full;
   assign do_rd   = rd_pop && !empty;
   assign rd_data = mem_q[rp_q];

   generate
      if (POW2) begin : g_wrap_free
         assign wp_nx = wp_q + 1'b1;
         assign rp_nx = rp_q + 1'b1;
      end else begin : g_wrap_cmp
         assign wp_nx = (wp_q == AW'(DEPTH - 1)) ? '0 : wp_q + 1'b1;
         assign rp_nx = (rp_q == AW'(DEPTH - 1)) ? '0 : rp_q + 1'b1;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (do_wr) mem_q[wp_q] <= wr_data;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wp_q     <= '0;
         rp_q     <= '0;
         cnt_q    <= '0;
         overflow <= 1'b0;
      end else begin
         if (do_wr) wp_q <= wp_nx;
         if (do_rd) rp_q <= rp_nx;
         case ({do_wr, do_rd})
            2'b10:   cnt_q <= cnt_q + 1'b1;
            2'b01:   cnt_q <= cnt_q - 1'b1;
            default: cnt_q <= cnt_q;
         endcase
         if (wr_ack && full) overflow <= 1'b1;
         else if (ovf_clr)   overflow <= 1'b0;
      end
   end

   // R3
   ovf_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(overflow) |-> $past(wr_ack && !dma_req));

   // R2
   cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_q == $past(cnt_q)) || (cnt_q == $past(cnt_q) + 1'b1) ||
      (cnt_q == $past(cnt_q) - 1'b1));

   // R3
   full_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_ack && full && !rd_pop) |=> !dma_req);
endmodule

// File: rtl/vf_serializer.sv
module vf_serializer
   import vf_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int LEN_W  = 14
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bit_en,
   input  logic              line_start,
   input  logic [LEN_W-1:0]  line_len,
   input  logic [DATA_W-1:0] rd_data,
   input  logic              empty,
   output logic              rd_pop,
   output logic              start_acc,
   output logic              video_out,
   output logic              video_vld,
   output logic              line_done,
   output logic              line_active,
   output logic              underrun
);
   localparam int BW = $clog2(DATA_W + 1);

   ser_state_t        state_q;
   logic [LEN_W-1:0]  left_q;
   logic [BW-1:0]     bits_q;
   logic [DATA_W-1:0] sh_q;
   logic              need_word;

   assign line_active = (state_q == SER_RUN);
   assign start_acc   = (state_q == SER_IDLE) && line_start;
   assign need_word   = line_active && bit_en && (bits_q == '0);
   assign rd_pop      = need_word && !empty;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q   <= SER_IDLE;
         left_q    <= '0;
         bits_q    <= '0;
         sh_q      <= '0;
         video_out <= 1'b0;
         video_vld <= 1'b0;
         line_done <= 1'b0;
         underrun  <= 1'b0;
      end else begin
         video_vld <= 1'b0;
         line_done <= 1'b0;
         if (start_acc) begin
            underrun <= 1'b0;
            if (line_len == '0) begin
               line_done <= 1'b1;
            end else begin
               state_q <= SER_RUN;
               left_q  <= line_len;
               bits_q  <= '0;
            end
         end else if (line_active && bit_en) begin
            video_vld <= 1'b1;
            if (bits_q == '0) begin
               if (!empty) begin
                  video_out <= rd_data[DATA_W-1];
                  sh_q      <= rd_data << 1;
                  bits_q    <= BW'(DATA_W - 1);
               end else begin
                  video_out <= 1'b0;
                  underrun  <= 1'b1;
               end
            end else begin
               video_out <= sh_q[DATA_W-1];
               sh_q      <= sh_q << 1;
               bits_q    <= bits_q - 1'b1;
            end
            left_q <= left_q - 1'b1;
            if (left_q == LEN_W'(1)) begin
               state_q   <= SER_IDLE;
               line_done <= 1'b1;
            end
         end
      end
   end

   // R7
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      line_done |=> !line_done);

   // R9
   udr_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (video_vld && $rose(underrun)) |-> !video_out);

   // R4
   vld_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
      video_vld |-> $past(bit_en));

   // R6
   start_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(line_active) |-> (left_q == $past(line_len)));
endmodule

// File: rtl/rline_vfifo.sv
module rline_vfifo #(
   parameter int DATA_W   = 8,
   parameter int DEPTH    = 1280,
   parameter int LEN_W    = $clog2(DEPTH * DATA_W + 1),
   parameter int RATE_NUM = 613,
   parameter int RATE_DEN = 25000
) (
   input  logic              clk,
   input  logic              rst_n,
   output logic              dma_req,
   input  logic              dma_ack,
   input  logic [DATA_W-1:0] dma_data,
   input  logic              line_start,
   input  logic [LEN_W-1:0]  line_len,
   output logic              video_out,
   output logic              video_vld,
   output logic              line_active,
   output logic              line_done,
   output logic              underrun,
   output logic              overflow
);
   generate
      if (LEN_W < 1 || LEN_W > 31) begin : g_bad_len
         $error("rline_vfifo: LEN_W must lie in 1..31");
      end
   endgenerate

   logic              bit_en;
   logic              rd_pop;
   logic              st_empty;
   logic              start_acc;
   logic [DATA_W-1:0] rd_data;

   vf_rate_gen #(
      .RATE_NUM (RATE_NUM),
      .RATE_DEN (RATE_DEN)
   ) u_rate (
      .clk    (clk),
      .rst_n  (rst_n),
      .bit_en (bit_en)
   );

   vf_store #(
      .DATA_W (DATA_W),
      .DEPTH  (DEPTH)
   ) u_store (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_ack   (dma_ack),
      .wr_data  (dma_data),
      .rd_pop   (rd_pop),
      .rd_data  (rd_data),
      .empty    (st_empty),
      .dma_req  (dma_req),
      .ovf_clr  (start_acc),
      .overflow (overflow)
   );

   vf_serializer #(
      .DATA_W (DATA_W),
      .LEN_W  (LEN_W)
   ) u_ser (
      .clk         (clk),
      .rst_n       (rst_n),
      .bit_en      (bit_en),
      .line_start  (line_start),
      .line_len    (line_len),
      .rd_data     (rd_data),
      .empty       (st_empty),
      .rd_pop      (rd_pop),
      .start_acc   (start_acc),
      .video_out   (video_out),
      .video_vld   (video_vld),
      .line_done   (line_done),
      .line_active (line_active),
      .underrun    (underrun)
   );

   // R8
   busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (line_active && line_start) |-> !start_acc);
endmodule

// File: tb/test_rline_vfifo.sv
`timescale 1ns/1ps
module test_rline_vfifo;
   localparam int DW  = 8;
   localparam int DEP = 8;
   localparam int LW  = 7;
   localparam int NUM = 1;
   localparam int DEN = 3;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          dma_ack = 1'b0;
   logic [DW-1:0] dma_data = '0;
   logic          line_start = 1'b0;
   logic [LW-1:0] line_len = '0;
   logic dma_req, video_out, video_vld, line_active, line_done, underrun, overflow;

   always #2 clk = ~clk;

   rline_vfifo #(
      .DATA_W(DW), .DEPTH(DEP), .LEN_W(LW), .RATE_NUM(NUM), .RATE_DEN(DEN)
   ) i_rline_vfifo (
      .clk(clk), .rst_n(rst_n), .dma_req(dma_req), .dma_ack(dma_ack),
      .dma_data(dma_data), .line_start(line_start), .line_len(line_len),
      .video_out(video_out), .video_vld(video_vld), .line_active(line_active),
      .line_done(line_done), .underrun(underrun), .overflow(overflow)
   );

   int total = 0;
   int bad   = 0;
   string phase = "R12";

   // inputs as seen by each rising edge
   logic          s_rst = 1'b0, s_ack = 1'b0, s_start = 1'b0, seen = 1'b0;
   logic [DW-1:0] s_data = '0;
   logic [LW-1:0] s_len = '0;
   always @(posedge clk) begin
      s_rst <= rst_n; s_ack <= dma_ack; s_data <= dma_data;
      s_start <= line_start; s_len <= line_len; seen <= 1'b1;
   end

   // behavioural reference state
   logic [DW-1:0] q[$];
   int   k, m_left, m_bits;
   bit   m_en, m_active, full_pre;
   logic [DW-1:0] m_sh;
   bit   e_vout, e_vld, e_done, e_udr, e_ovf;

   task automatic chk(input string req, input int act, input int exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s (%s) t=%0t act=%0d exp=%0d", req, phase, $time, act, exp);
      end
   endtask

   always @(negedge clk) begin
      if (seen) begin
         if (!s_rst) begin
            q.delete(); k = 0; m_left = 0; m_bits = 0; m_en = 0; m_active = 0;
            m_sh = '0; e_vout = 0; e_vld = 0; e_done = 0; e_udr = 0; e_ovf = 0;
         end else begin
            k++;
            full_pre = (q.size() >= DEP);
            e_vld = 0; e_done = 0;
            if (m_active && m_en) begin
               e_vld = 1;
               if (m_bits == 0) begin
                  if (q.size() > 0) begin
                     m_sh = q.pop_front(); e_vout = m_sh[DW-1];
                     m_sh = m_sh << 1; m_bits = DW - 1;
                  end else begin
                     e_vout = 0; e_udr = 1;
                  end
               end else begin
                  e_vout = m_sh[DW-1]; m_sh = m_sh << 1; m_bits--;
               end
               m_left--;
               if (m_left == 0) begin m_active = 0; e_done = 1; end
            end else if (!m_active && s_start) begin
               e_udr = 0; e_ovf = 0;
               if (s_len == 0) e_done = 1;
               else begin m_active = 1; m_left = int'(s_len); m_bits = 0; end
            end
            if (s_ack && full_pre) e_ovf = 1;
            else if (s_ack) q.push_back(s_data);
            m_en = ((k * NUM) / DEN) > (((k - 1) * NUM) / DEN);
         end
         chk("R1 dma_req",     int'(dma_req),     int'(q.size() < DEP));
         chk("R5 video_out",   int'(video_out),   int'(e_vout));
         chk("R4 video_vld",   int'(video_vld),   int'(e_vld));
         chk("R7 line_done",   int'(line_done),   int'(e_done));
         chk("R6 line_active", int'(line_active), int'(m_active));
         chk("R9 underrun",    int'(underrun),    int'(e_udr));
         chk("R3 overflow",    int'(overflow),    int'(e_ovf));
      end
   end

   task automatic push(input logic [DW-1:0] b);
      dma_ack = 1'b1; dma_data = b;
      @(posedge clk); #1 dma_ack = 1'b0;
   endtask

   task automatic start(input int len);
      line_start = 1'b1; line_len = LW'(len);
      @(posedge clk); #1 line_start = 1'b0;
   endtask

   task automatic wait_done();
      for (int i = 0; i < 2000; i++) begin
         @(posedge clk); #1;
         if (line_done) begin
            repeat (3) @(posedge clk);
            #1;
            return;
         end
      end
      chk("R7 line_done timeout", 0, 1);
   endtask

   initial begin
      #(4 * 150000);
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      // R12 reset state
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      repeat (5) @(posedge clk);
      #1;
      // R2 R5 whole-byte line with mixed patterns
      phase = "R2_R5";
      push(8'hA5); push(8'h3C); push(8'hF0); push(8'h81); push(8'h7E);
      start(40);
      wait_done();
      // R6 partial byte: leftover bits dropped, next line on fresh byte
      phase = "R6";
      push(8'hC3); push(8'h5A); push(8'h96);
      start(12);
      repeat (6) @(posedge clk);
      #1;
      // R8 start during active line ignored
      phase = "R8";
      start(3);
      wait_done();
      // R9 line longer than stored data
      phase = "R9";
      start(16);
      wait_done();
      // R11 zero length, R10 clears underrun
      phase = "R11_R10";
      start(0);
      repeat (4) @(posedge clk);
      #1;
      // R1 R3 fill and overflow
      phase = "R1_R3";
      for (int i = 0; i < DEP + 2; i++) push(8'(8'h11 * (i + 1)));
      repeat (2) @(posedge clk);
      #1;
      // R10 set wins over clear at start
      phase = "R10";
      dma_ack = 1'b1; dma_data = 8'hEE;
      start(64);
      dma_ack = 1'b0;
      // R2 writes during a running line
      phase = "R2";
      for (int i = 0; i < 6; i++) begin
         repeat (20) @(posedge clk);
         #1;
         push(8'(8'h29 + i * 8'h13));
      end
      wait_done();
      phase = "R10";
      start(8);
      wait_done();
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule